// File: doc/BRIEF.md
# DRAM Initialisation and Refresh Scheduler

This block owns the refresh side of an asynchronous DRAM controller. After reset it waits out a mandatory power-up pause, runs a fixed burst of wake-up refresh cycles, and only then declares the memory usable. From then on a free-running interval timer marks one distributed refresh due per interval, which spreads the full row count evenly over the retention period. Each refresh is a CAS-before-RAS cycle: the row address is don't-care, so no address counter is needed.

The RAS, CAS and write-enable strobes are shared with the access controller. The scheduler raises a bus request and drives the strobes only after the grant arrives. It keeps the bus until its sequence is finished. A refresh that has fallen due but has not yet been granted is counted as pending. A sticky overflow flag reports when more refreshes are pending than the configured limit.

A self-refresh request wraps a long RAS-low hold between two ordinary refresh cycles, one before and one after. On exit the precharge time depends on how long RAS was held low.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, and on leaving it, `ras_n`, `cas_n` and `we_n` are 1 and `bus_req`, `ready`, `in_self`, `pending` and `overflow` are 0.
- R2: `bus_req` is first seen high exactly INIT_CYCLES clock edges after reset is released, and the strobes stay high until then.
- R3: Exactly WAKE_REFRESHES refresh cycles (counted as falling edges of `ras_n`) complete before `ready` rises. Once high, `ready` stays high until reset.
- R4: Every refresh cycle drives `cas_n` low for T_CSR cycles with `ras_n` high, then holds both low for T_RAS cycles, then holds both high for T_RP cycles (precharge). `ras_n` is never low while `cas_n` is high, and `we_n` is 1 throughout.
- R5: The strobes are driven low only while `bus_req` is high. After `bus_req` rises, the strobes stay high until `bus_gnt` is seen. While the grant is withheld, `ras_n` and `cas_n` remain 1.
- R6: Once `ready` is high, one refresh falls due every INTERVAL = PERIOD_CYCLES / ROWS cycles. The interval timer reloads when the refresh falls due, not when it is granted. With an immediate grant, successive `ras_n` falling edges are exactly INTERVAL cycles apart.
- R7: `pending` counts refreshes that have fallen due but whose bus grant has not yet been taken. It rises by one per due refresh, falls by one per granted refresh, and saturates at MAX_PENDING+1.
- R8: `overflow` rises when `pending` exceeds MAX_PENDING and stays high until reset, even after the backlog drains.
- R9: When `self_req` is high with `ready` set, one complete refresh cycle is issued first. Then `cas_n` falls, and after T_CSR cycles `ras_n` falls and stays low (with `in_self` high) for as long as `self_req` stays high. The RAS-low time equals the number of cycles until `self_req` is seen low.
- R10: If the self-refresh RAS-low time is at least SELF_LONG cycles, the exit precharge lasts T_RPS cycles; otherwise it lasts T_RP cycles.
- R11: Immediately after the exit precharge, one ordinary refresh cycle follows without releasing `bus_req`. The bus is then released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_req | input | 1 | Hold high to enter and stay in self refresh |
| bus_gnt | input | 1 | Strobe ownership granted by the access controller |
| bus_req | output | 1 | Strobe ownership requested and held |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low (all byte lanes together) |
| we_n | output | 1 | Write enable, active low; held high |
| ready | output | 1 | Initialisation complete |
| in_self | output | 1 | RAS held low in self refresh |
| pending | output | PW | Due refreshes not yet granted |
| overflow | output | 1 | Sticky: backlog exceeded MAX_PENDING |

## Verification
All strobe outputs come straight from the state register. A change therefore shows one edge after the state transition. Refresh phases span T_CSR, T_RAS and T_RP edges, and a due refresh reaches the `ras_n` fall four edges after the timer expires (pending update, request, grant, column-strobe setup). A monitor samples every falling clock edge and measures each strobe phase in whole cycles. Tasks act one time unit after that sample, and time the backlog checks in the middle of an interval so that they never share a cycle with a timer expiry. Self-refresh hold times are chosen at SELF_LONG-1 and SELF_LONG to pin down the boundary between the two precharge lengths.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_REQ,
        ST_CSR,
        ST_RAS,
        ST_SELF,
        ST_PRE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_PLAIN,
        PH_BEFORE,
        PH_ENTER,
        PH_AFTER
    } seq_phase_t;

endpackage

// File: rtl/refresh_tick_timer.sv
module refresh_tick_timer #(
    parameter int INTERVAL    = 1562,
    parameter int MAX_PENDING = 4,
    parameter int PW          = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          take,
    output logic [PW-1:0] pending,
    output logic          overflow
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] RELOAD   = TW'(INTERVAL - 1);
    localparam logic [PW-1:0] PEND_SAT = PW'(MAX_PENDING + 1);
    localparam logic [PW-1:0] PEND_LIM = PW'(MAX_PENDING);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [PW-1:0] pend;
        logic          ovf;
    } tick_t;

    tick_t s_d, s_q;
    logic  due;

    always_comb begin
        s_d = s_q;
        due = 1'b0;
        // reload on expiry so the average rate does not drift with grant latency
        if (!run) begin
            s_d.tmr = RELOAD;
        end else if (s_q.tmr == '0) begin
            s_d.tmr = RELOAD;
            due     = 1'b1;
        end else begin
            s_d.tmr = s_q.tmr - 1'b1;
        end
        unique case ({due, take && (s_q.pend != '0)})
            2'b10:   if (s_q.pend != PEND_SAT) s_d.pend = s_q.pend + 1'b1;
            2'b01:   s_d.pend = s_q.pend - 1'b1;
            default: s_d.pend = s_q.pend;
        endcase
        if (s_d.pend > PEND_LIM) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.tmr  <= RELOAD;
            s_q.pend <= '0;
            s_q.ovf  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pending  = s_q.pend;
    assign overflow = s_q.ovf;

endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
    import dram_refresh_pkg::*;
#(
    parameter int INIT_CYCLES    = 20000,
    parameter int WAKE_REFRESHES = 8,
    parameter int T_CSR          = 1,
    parameter int T_RAS          = 5,
    parameter int T_RP           = 4,
    parameter int T_RPS          = 11,
    parameter int SELF_LONG      = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic self_req,
    input  logic bus_gnt,
    input  logic pend_nz,
    output logic take,
    output logic ready,
    output logic in_self,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n
);
    localparam int CNT_MAX = INIT_CYCLES + T_CSR + T_RAS + T_RP + T_RPS;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int HW      = (SELF_LONG > 2) ? $clog2(SELF_LONG) : 1;
    localparam int WW      = $clog2(WAKE_REFRESHES + 1);

    localparam logic [CW-1:0] INIT_LD = CW'(INIT_CYCLES - 1);
    localparam logic [CW-1:0] CSR_LD  = CW'(T_CSR - 1);
    localparam logic [CW-1:0] RAS_LD  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RP_LD   = CW'(T_RP - 1);
    localparam logic [CW-1:0] RPS_LD  = CW'(T_RPS - 1);
    localparam logic [HW-1:0] HOLD_TOP = HW'(SELF_LONG - 1);
    localparam logic [WW-1:0] WAKE_LD = WW'(WAKE_REFRESHES);

    typedef struct packed {
        seq_state_t    state;
        seq_phase_t    phase;
        logic [CW-1:0] cnt;
        logic [HW-1:0] hold;
        logic [WW-1:0] wake;
        logic          ready;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        unique case (s_q.state)
            ST_INIT: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_REQ;
                    s_d.phase = PH_PLAIN;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_IDLE: begin
                if (s_q.wake != '0) begin
                    s_d.state = ST_REQ;
                    s_d.phase = PH_PLAIN;
                end else if (self_req) begin
                    s_d.state = ST_REQ;
                    s_d.phase = PH_BEFORE;
                end else if (pend_nz) begin
                    s_d.state = ST_REQ;
                    s_d.phase = PH_PLAIN;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    s_d.state = ST_CSR;
                    s_d.cnt   = CSR_LD;
                    take      = s_q.ready && pend_nz;
                end
            end
            ST_CSR: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.phase == PH_ENTER) begin
                    s_d.state = ST_SELF;
                    s_d.hold  = '0;
                end else begin
                    s_d.state = ST_RAS;
                    s_d.cnt   = RAS_LD;
                end
            end
            ST_RAS: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.state = ST_PRE;
                    s_d.cnt   = RP_LD;
                end
            end
            ST_SELF: begin
                if (s_q.hold != HOLD_TOP) s_d.hold = s_q.hold + 1'b1;
                if (!self_req) begin
                    s_d.state = ST_PRE;
                    s_d.cnt   = (s_q.hold == HOLD_TOP) ? RPS_LD : RP_LD;
                end
            end
            ST_PRE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    unique case (s_q.phase)
                        PH_BEFORE: begin
                            s_d.state = ST_CSR;
                            s_d.phase = PH_ENTER;
                            s_d.cnt   = CSR_LD;
                        end
                        PH_ENTER: begin
                            s_d.state = ST_CSR;
                            s_d.phase = PH_AFTER;
                            s_d.cnt   = CSR_LD;
                        end
                        default: begin
                            s_d.state = ST_IDLE;
                            s_d.phase = PH_PLAIN;
                            if (s_q.wake != '0) begin
                                s_d.wake = s_q.wake - 1'b1;
                                if (s_q.wake == WW'(1)) s_d.ready = 1'b1;
                            end
                        end
                    endcase
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state <= ST_INIT;
            s_q.phase <= PH_PLAIN;
            s_q.cnt   <= INIT_LD;
            s_q.hold  <= '0;
            s_q.wake  <= WAKE_LD;
            s_q.ready <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready   = s_q.ready;
    assign in_self = (s_q.state == ST_SELF);
    assign ras_n   = !((s_q.state == ST_RAS) || (s_q.state == ST_SELF));
    assign cas_n   = !((s_q.state == ST_CSR) || (s_q.state == ST_RAS) ||
                       (s_q.state == ST_SELF));
    assign bus_req = (s_q.state != ST_INIT) && (s_q.state != ST_IDLE);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int INIT_CYCLES    = 20000,
    parameter int WAKE_REFRESHES = 8,
    parameter int ROWS           = 4096,
    parameter int PERIOD_CYCLES  = 6400000,
    parameter int T_CSR          = 1,
    parameter int T_RAS          = 5,
    parameter int T_RP           = 4,
    parameter int T_RPS          = 11,
    parameter int SELF_LONG      = 10000,
    parameter int MAX_PENDING    = 4,
    parameter int PW             = $clog2(MAX_PENDING + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          self_req,
    input  logic          bus_gnt,
    output logic          bus_req,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          ready,
    output logic          in_self,
    output logic [PW-1:0] pending,
    output logic          overflow
);
    localparam int INTERVAL = PERIOD_CYCLES / ROWS;

    logic take;
    logic run;

    assign run  = ready && !in_self;
    assign we_n = 1'b1;

    refresh_tick_timer #(
        .INTERVAL   (INTERVAL),
        .MAX_PENDING(MAX_PENDING),
        .PW         (PW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .take    (take),
        .pending (pending),
        .overflow(overflow)
    );

    cbr_sequencer #(
        .INIT_CYCLES   (INIT_CYCLES),
        .WAKE_REFRESHES(WAKE_REFRESHES),
        .T_CSR         (T_CSR),
        .T_RAS         (T_RAS),
        .T_RP          (T_RP),
        .T_RPS         (T_RPS),
        .SELF_LONG     (SELF_LONG)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .self_req(self_req),
        .bus_gnt (bus_gnt),
        .pend_nz (pending != '0),
        .take    (take),
        .ready   (ready),
        .in_self (in_self),
        .bus_req (bus_req),
        .ras_n   (ras_n),
        .cas_n   (cas_n)
    );

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          bus_req,
    input logic          ready,
    input logic          in_self,
    input logic [PW-1:0] pending,
    input logic          overflow
);
    // R4: column strobe leads the row strobe
    assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    // R4: row strobe never low alone
    assert_ras_needs_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R5: strobes only driven while the bus is requested
    assert_strobe_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> bus_req);

    // R5: a new request starts with idle strobes
    assert_req_starts_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (ras_n && cas_n));

    // R3: ready holds once reached
    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R7: backlog moves by at most one per cycle
    assert_pending_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != $past(pending)) |->
            ((pending == $past(pending) + 1'b1) || (pending == $past(pending) - 1'b1)));

    // R8: overflow is sticky
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9: self refresh holds both strobes low
    assert_self_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_self |-> (!ras_n && !cas_n && ready));

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .bus_req (bus_req),
    .ready   (ready),
    .in_self (in_self),
    .pending (pending),
    .overflow(overflow)
);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
    localparam int CLK_PERIOD  = 10;
    localparam int INIT_CYC    = 50;
    localparam int WAKE_N      = 8;
    localparam int ROWS_N      = 64;
    localparam int PERIOD_N    = 6400;
    localparam int INTERVAL    = PERIOD_N / ROWS_N;
    localparam int TCSR        = 2;
    localparam int TRAS        = 4;
    localparam int TRP         = 3;
    localparam int TRPS        = 10;
    localparam int LONG_N      = 40;
    localparam int MAXP        = 2;
    localparam int PWB         = $clog2(MAXP + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic self_req = 1'b0;
    logic gnt_block = 1'b0;
    logic bus_gnt, bus_req, ras_n, cas_n, we_n, ready, in_self, overflow;
    logic [PWB-1:0] pending;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // monitor state
    int cyc = 0, ras_falls = 0, fall_prev = 0, fall_last = 0;
    int cas_run = 0, csr_len = 0, ras_run = 0, ras_len = 0;
    int pre_run = 0, pre_len = 0, self_pre_len = 0, self_ras_len = 0;
    bit pre_active = 0, prev_ras = 1;
    int we_low_seen = 0, strobe_blocked = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_gnt = bus_req && !gnt_block;

    dram_refresh_sched #(
        .INIT_CYCLES(INIT_CYC), .WAKE_REFRESHES(WAKE_N), .ROWS(ROWS_N),
        .PERIOD_CYCLES(PERIOD_N), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP),
        .T_RPS(TRPS), .SELF_LONG(LONG_N), .MAX_PENDING(MAXP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .self_req(self_req), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ready(ready), .in_self(in_self), .pending(pending), .overflow(overflow)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; ras_falls = 0; cas_run = 0; ras_run = 0;
            pre_active = 0; prev_ras = 1;
        end else begin
            cyc++;
            if (!we_n) we_low_seen++;
            if ((!ras_n || !cas_n) && gnt_block) strobe_blocked++;
            if (!cas_n && ras_n) cas_run++;
            else if (cas_n) cas_run = 0;
            if (!ras_n && prev_ras) begin
                ras_falls++; fall_prev = fall_last; fall_last = cyc; csr_len = cas_run;
            end
            if (!ras_n) ras_run++;
            if (ras_n && !prev_ras) begin
                ras_len = ras_run; ras_run = 0; pre_active = 1; pre_run = 1;
            end else if (pre_active) begin
                if (ras_n && cas_n && bus_req) pre_run++;
                else begin
                    pre_len = pre_run; pre_active = 0;
                    if (ras_len != TRAS) begin
                        self_pre_len = pre_run; self_ras_len = ras_len;
                    end
                end
            end
            prev_ras = ras_n;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic check(string req, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic wait_until(int target);
        while (cyc < target) step();
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) step();
        check("R1", "ras_n", int'(ras_n), 1);
        check("R1", "cas_n", int'(cas_n), 1);
        check("R1", "we_n", int'(we_n), 1);
        check("R1", "bus_req", int'(bus_req), 0);
        check("R1", "ready", int'(ready), 0);
        check("R1", "in_self", int'(in_self), 0);
        check("R1", "pending", int'(pending), 0);
        check("R1", "overflow", int'(overflow), 0);
    endtask

    task automatic test_init();
        int n = 0;
        int early = 0;
        rst_n = 1'b1;
        while (!bus_req) begin
            step(); n++;
            if (!ras_n || !cas_n) early++;
        end
        check("R2", "edges to first request", n, INIT_CYC);
        check("R2", "strobes during pause", early, 0);
        while (!ready) step();
        check("R3", "wake refreshes before ready", ras_falls, WAKE_N);
        check("R4", "cas lead cycles", csr_len, TCSR);
        check("R4", "ras low cycles", ras_len, TRAS);
        check("R4", "precharge cycles", pre_len, TRP);
    endtask

    task automatic test_interval();
        int base = ras_falls;
        while (ras_falls < base + 3) step();
        check("R6", "refresh spacing", fall_last - fall_prev, INTERVAL);
        check("R3", "ready still high", int'(ready), 1);
        while (bus_req) step();
        check("R4", "regular cas lead", csr_len, TCSR);
        check("R4", "regular ras low", ras_len, TRAS);
        check("R4", "regular precharge", pre_len, TRP);
        check("R4", "we_n low samples", we_low_seen, 0);
    endtask

    task automatic test_backlog();
        int t0, base;
        base = ras_falls;
        while (ras_falls == base) step();
        t0 = fall_last;
        while (bus_req) step();
        gnt_block = 1'b1;
        wait_until(t0 + 2 * INTERVAL + INTERVAL / 2);
        check("R7", "pending after two due", int'(pending), 2);
        check("R8", "no overflow at limit", int'(overflow), 0);
        check("R5", "request held while blocked", int'(bus_req), 1);
        wait_until(t0 + 3 * INTERVAL + INTERVAL / 2);
        check("R7", "pending after three due", int'(pending), 3);
        check("R8", "overflow above limit", int'(overflow), 1);
        wait_until(t0 + 4 * INTERVAL + INTERVAL / 2);
        check("R7", "pending saturates", int'(pending), MAXP + 1);
        check("R5", "strobe samples while blocked", strobe_blocked, 0);
        base = ras_falls;
        gnt_block = 1'b0;
        repeat (40) step();
        check("R7", "backlog drained", int'(pending), 0);
        check("R7", "refreshes on release", ras_falls - base, MAXP + 1);
        check("R8", "overflow sticky", int'(overflow), 1);
    endtask

    task automatic test_self(int hold, int exp_pre, string tag);
        int base, bad = 0;
        while (bus_req) step();
        base = ras_falls;
        self_req = 1'b1;
        while (!in_self) step();
        for (int i = 1; i < hold; i++) begin
            step();
            if (!in_self || ras_n) bad++;
        end
        self_req = 1'b0;
        step();
        check("R9", {tag, " in_self dropped"}, int'(in_self), 0);
        check("R9", {tag, " hold violations"}, bad, 0);
        while (bus_req) step();
        check("R9", {tag, " ras low length"}, self_ras_len, hold);
        check("R10", {tag, " exit precharge"}, self_pre_len, exp_pre);
        check("R11", {tag, " refreshes around self"}, ras_falls - base, 3);
        check("R11", {tag, " trailing ras low"}, ras_len, TRAS);
    endtask

    initial begin
        test_reset();
        test_init();
        test_interval();
        test_backlog();
        test_self(10, TRP, "short");
        test_self(LONG_N - 1, TRP, "below");
        test_self(LONG_N, TRPS, "at");
        test_reset();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule